// File: doc/BRIEF.md
# Block-Granular DMA Channel

This block is a single DMA channel that carries 16-bit halfwords between a peripheral-side FIFO and system memory. It always moves whole 64-byte blocks. Software sets a mode word (enable, direction, interrupt enable), a block-aligned load address and a count of blocks. The engine then walks a current-address pointer through memory one block at a time. When the count reaches zero it raises a pending flag, so software can chain the next segment. It does this by loading a new address and writing a new nonzero count, which restarts the channel at once. Software can also push or pop the FIFO directly in halfword units while the channel is enabled. This lets it prime a partial leading block or drain a trailing one.

In the to-memory direction the peripheral fills the FIFO. Once a full block is buffered, the engine writes its 32 halfwords to consecutive memory addresses. In the from-memory direction the engine waits for an empty FIFO, fetches a block, and the peripheral drains it in order.

The engine is a four-state machine:
- `ST_IDLE` goes to `ST_WAIT` when the channel is enabled and the count is nonzero.
- `ST_WAIT` goes to `ST_MOVE` when the FIFO is full (to memory) or empty (from memory). It returns to `ST_IDLE` if the channel is disabled.
- `ST_MOVE` issues one memory request per beat and goes to `ST_NEXT` on the acknowledge of the 32nd beat. It returns to `ST_IDLE` if the channel is disabled.
- `ST_NEXT` decrements the count and advances the address by 64. It returns to `ST_IDLE` when the count becomes zero, and to `ST_WAIT` otherwise.

Any write to the count register forces `ST_IDLE` and reloads the address.

Top module: `blkdma_chan`

## Requirements
- R1: After reset, the mode register reads 0x20 (FIFO empty flag only), the count and current address read 0, and `irq` is low.
- R2: The load address register forces its low 6 bits to zero. Writing 0xFFFFFFFF reads back 0xFFFFFFC0, and the current address is always block aligned.
- R3: A write to the count register (address 2) copies the load address into the current address on the next cycle. While enabled, a nonzero count starts moving blocks from that address.
- R4: Each completed block decrements the count by one and advances the current address by 64 in the same cycle. After n blocks the current address is the load address plus 64·n.
- R5: The pending flag (mode read bit 6) rises only when the count steps from 1 to 0. `irq` is high only while pending is set and interrupt enable (bit 10) is set.
- R6: Any write to the count register clears the pending flag, and with it `irq`.
- R7: Mode read layout: bits 4:0 give the FIFO halfword level, bit 5 is FIFO empty, bit 6 pending, bit 7 error, bit 8 enable, bit 9 direction (1 = to memory), bit 10 interrupt enable.
- R8: While enabled, a write to the FIFO register (address 4) pushes `reg_wdata[15:0]`, and a read returns the head halfword and pops it. While disabled, both are ignored.
- R9: Writing the mode register with bit 11 set empties the FIFO by the next cycle. Bit 11 is self-clearing and reads back as its level/flag meaning, not as a stored command.
- R10: A CPU push into a full FIFO or a pop from an empty FIFO sets the error flag (bit 7). Writing the mode register with bit 12 set clears it. Bit 12 is self-clearing.
- R11: Writing the count to zero and then the mode register to zero stops the channel. No memory request is issued while disabled or while the count is zero.
- R12: In the to-memory direction, halfwords from the peripheral port are written to consecutive halfword addresses of the current block, in arrival order. Every request lies inside the current block.
- R13: In the from-memory direction, each block is read from consecutive halfword addresses into the FIFO and delivered on the peripheral output in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO at address 4) |
| reg_addr | input | 3 | Register select: 0 mode, 1 load, 2 count, 3 current, 4 FIFO |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt: pending and enabled |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write (to-memory direction) |
| mem_addr | output | ADDR_W | Byte address of the halfword beat |
| mem_wdata | output | 16 | Halfword written to memory |
| mem_rdata | input | 16 | Halfword read from memory |
| mem_ack | input | 1 | Beat accepted this cycle |
| pin_valid | input | 1 | Peripheral offers a halfword |
| pin_data | input | 16 | Peripheral halfword into the FIFO |
| pin_ready | output | 1 | FIFO accepts the peripheral halfword |
| pout_valid | output | 1 | FIFO offers a halfword to the peripheral |
| pout_data | output | 16 | Halfword out of the FIFO |
| pout_ready | input | 1 | Peripheral takes the halfword |

## Verification
The bound checker watches properties that hold on every cycle:
- the current address stays block aligned;
- a count write reloads the current address from the load address;
- every count step is paired with a 64-byte address step;
- pending rises only on the step from one to zero and is cleared by a count write;
- a clear-FIFO command leaves the FIFO empty;
- no memory request is made when the channel is disabled or the count is zero;
- every request lands inside the current block.

Only the bench scenarios can show end-to-end data order. They do this by sweeping block counts 1 to 3 and two load offsets (one unaligned) in both directions, and comparing memory contents and peripheral output with arithmetic patterns. They also cover chaining to a new address, interrupt gating, CPU priming, the error flag, and the stop sequence.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
    localparam logic [2:0] RA_MODE  = 3'd0;
    localparam logic [2:0] RA_LOAD  = 3'd1;
    localparam logic [2:0] RA_COUNT = 3'd2;
    localparam logic [2:0] RA_CURR  = 3'd3;
    localparam logic [2:0] RA_FIFO  = 3'd4;

    localparam int MB_EMPTY = 5;
    localparam int MB_PEND  = 6;
    localparam int MB_ERR   = 7;
    localparam int MB_EN    = 8;
    localparam int MB_DIR   = 9;
    localparam int MB_IE    = 10;
    localparam int MB_CLRF  = 11;
    localparam int MB_CLRE  = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MOVE = 2'd2,
        ST_NEXT = 2'd3
    } eng_state_e;
endpackage

// File: rtl/blkdma_fifo.sv
module blkdma_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level
);
    logic [W-1:0]  store_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] lvl_q;
    logic          push_ok, pop_ok;

    assign push_ok = push && (lvl_q != LW'(DEPTH));
    assign pop_ok  = pop && (lvl_q != '0);
    assign rdata   = store_q[rp_q];
    assign level   = lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + 1'b1;
            if (pop_ok)  rp_q <= rp_q + 1'b1;
            lvl_q <= lvl_q + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) store_q[wp_q] <= wdata;
    end
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int BLK_BYTES = 64,
    localparam int BEATS    = BLK_BYTES / 2,
    localparam int BW       = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          to_mem,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic [AW-1:0] load_addr,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          eng_push,
    output logic          eng_pop,
    output logic          last_done,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] blkcnt
);
    eng_state_e    state_q, state_d;
    logic [BW-1:0] beat_q;
    logic [AW-1:0] cur_q;
    logic [CW-1:0] cnt_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (cnt_wr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (en && cnt_q != '0) state_d = ST_WAIT;
                ST_WAIT: begin
                    if (!en) state_d = ST_IDLE;
                    else if (to_mem ? fifo_full : fifo_empty) state_d = ST_MOVE;
                end
                ST_MOVE: begin
                    if (!en) state_d = ST_IDLE;
                    else if (mem_ack && beat_q == BW'(BEATS - 1)) state_d = ST_NEXT;
                end
                ST_NEXT: state_d = (cnt_q == CW'(1)) ? ST_IDLE : ST_WAIT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // block pointer, count and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            cur_q  <= '0;
            cnt_q  <= '0;
        end else if (cnt_wr) begin
            beat_q <= '0;
            cur_q  <= load_addr;
            cnt_q  <= cnt_wdata;
        end else begin
            if (state_q != ST_MOVE)       beat_q <= '0;
            else if (mem_ack && en)       beat_q <= beat_q + 1'b1;
            if (state_q == ST_NEXT) begin
                cnt_q <= cnt_q - CW'(1);
                cur_q <= cur_q + AW'(BLK_BYTES);
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_MOVE) && en;
        mem_addr  = cur_q | AW'({beat_q, 1'b0});
        eng_push  = mem_req && mem_ack && !to_mem;
        eng_pop   = mem_req && mem_ack && to_mem;
        last_done = (state_q == ST_NEXT) && (cnt_q == CW'(1)) && !cnt_wr;
        cur_addr  = cur_q;
        blkcnt    = cnt_q;
    end
endmodule

// File: rtl/blkdma_chan.sv
module blkdma_chan
    import blkdma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int HW_W      = 16,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [HW_W-1:0]   mem_wdata,
    input  logic [HW_W-1:0]   mem_rdata,
    input  logic              mem_ack,
    input  logic              pin_valid,
    input  logic [HW_W-1:0]   pin_data,
    output logic              pin_ready,
    output logic              pout_valid,
    output logic [HW_W-1:0]   pout_data,
    input  logic              pout_ready
);
    localparam int HW_PER_BLK = BLK_BYTES / 2;
    localparam int LVL_W      = $clog2(HW_PER_BLK) + 1;
    localparam int OFS        = $clog2(BLK_BYTES);

    logic              en_q, dir_q, ie_q, err_q, pend_q;
    logic [ADDR_W-1:0] load_q, cur_addr;
    logic [CNT_W-1:0]  blkcnt;
    logic              mode_wr, cnt_wr, fifo_clr, cpu_push, cpu_pop;
    logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
    logic [LVL_W-1:0]  fifo_level;
    logic [HW_W-1:0]   fifo_rdata, fifo_wdata;
    logic              eng_push, eng_pop, last_done;

    assign mode_wr  = reg_wr && reg_addr == RA_MODE;
    assign cnt_wr   = reg_wr && reg_addr == RA_COUNT;
    assign fifo_clr = mode_wr && reg_wdata[MB_CLRF];
    assign cpu_push = reg_wr && reg_addr == RA_FIFO && en_q;
    assign cpu_pop  = reg_rd && reg_addr == RA_FIFO && en_q;

    assign fifo_full  = fifo_level == LVL_W'(HW_PER_BLK);
    assign fifo_empty = fifo_level == '0;

    assign pin_ready  = en_q && dir_q && !fifo_full && !cpu_push;
    assign pout_valid = en_q && !dir_q && !fifo_empty && !cpu_pop;
    assign pout_data  = fifo_rdata;

    assign fifo_push  = eng_push || cpu_push || (pin_valid && pin_ready);
    assign fifo_wdata = eng_push ? mem_rdata : (cpu_push ? reg_wdata[HW_W-1:0] : pin_data);
    assign fifo_pop   = eng_pop || cpu_pop || (pout_valid && pout_ready);

    assign mem_we    = dir_q;
    assign mem_wdata = fifo_rdata;
    assign irq       = pend_q && ie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            dir_q  <= 1'b0;
            ie_q   <= 1'b0;
            err_q  <= 1'b0;
            pend_q <= 1'b0;
            load_q <= '0;
        end else begin
            if (mode_wr) begin
                en_q  <= reg_wdata[MB_EN];
                dir_q <= reg_wdata[MB_DIR];
                ie_q  <= reg_wdata[MB_IE];
            end
            if (reg_wr && reg_addr == RA_LOAD)
                load_q <= {reg_wdata[ADDR_W-1:OFS], OFS'(0)};
            if (mode_wr && reg_wdata[MB_CLRE])
                err_q <= 1'b0;
            else if ((cpu_push && fifo_full) || (cpu_pop && fifo_empty))
                err_q <= 1'b1;
            if (cnt_wr)         pend_q <= 1'b0;
            else if (last_done) pend_q <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_MODE:  reg_rdata = 32'({ie_q, dir_q, en_q, err_q, pend_q, fifo_empty,
                                       fifo_level[LVL_W-2:0]});
            RA_LOAD:  reg_rdata = 32'(load_q);
            RA_COUNT: reg_rdata = 32'(blkcnt);
            RA_CURR:  reg_rdata = 32'(cur_addr);
            RA_FIFO:  reg_rdata = (en_q && !fifo_empty) ? 32'(fifo_rdata) : 32'd0;
            default:  reg_rdata = 32'd0;
        endcase
    end

    blkdma_fifo #(.W(HW_W), .DEPTH(HW_PER_BLK)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .level (fifo_level)
    );

    blkdma_engine #(.AW(ADDR_W), .CW(CNT_W), .BLK_BYTES(BLK_BYTES)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .to_mem     (dir_q),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (reg_wdata[CNT_W-1:0]),
        .load_addr  (load_q),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .eng_push   (eng_push),
        .eng_pop    (eng_pop),
        .last_done  (last_done),
        .cur_addr   (cur_addr),
        .blkcnt     (blkcnt)
    );
endmodule

// File: rtl/blkdma_chan_chk.sv
module blkdma_chan_chk #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int BLK_BYTES = 64,
    localparam int OFS      = $clog2(BLK_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_q,
    input logic              cnt_wr,
    input logic [ADDR_W-1:0] load_q,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  blkcnt,
    input logic              pend_q,
    input logic              irq,
    input logic              fifo_clr,
    input logic              fifo_empty,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr
);
    p_cur_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_addr[OFS-1:0] == '0);

    p_restart_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr) |-> cur_addr == $past(load_q));

    p_block_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr) && blkcnt != $past(blkcnt)) |->
        (blkcnt == $past(blkcnt) - CNT_W'(1) && cur_addr == $past(cur_addr) + ADDR_W'(BLK_BYTES)));

    p_pend_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> (blkcnt == '0 && $past(blkcnt) == CNT_W'(1)));

    p_irq_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> blkcnt == '0);

    p_pend_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr) |-> !pend_q);

    p_clr_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_clr) |-> fifo_empty);

    p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q || blkcnt == '0) |-> !mem_req);

    p_req_in_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[ADDR_W-1:OFS] == cur_addr[ADDR_W-1:OFS]);
endmodule

bind blkdma_chan blkdma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .cnt_wr     (cnt_wr),
    .load_q     (load_q),
    .cur_addr   (cur_addr),
    .blkcnt     (blkcnt),
    .pend_q     (pend_q),
    .irq        (irq),
    .fifo_clr   (fifo_clr),
    .fifo_empty (fifo_empty),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr)
);

// File: tb/blkdma_chan_tb.sv
module blkdma_chan_tb_top;
    localparam int PERIOD = 10;
    localparam logic [31:0] M_EN = 32'h100, M_DIR = 32'h200, M_IE = 32'h400,
                            M_CLRF = 32'h800, M_CLRE = 32'h1000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0, reg_rdata;
    logic        irq, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        pin_valid, pin_ready, pout_valid, pout_ready;
    logic [15:0] pin_data, pout_data;

    int errors = 0, checks = 0;
    logic        stall_q = 1'b0;
    logic [15:0] wmem [256];
    logic [15:0] seed = 16'h5a3c;
    logic        src_on = 1'b0, sink_on = 1'b0;
    int          src_seq = 0, sink_n = 0;
    logic [15:0] sink [1024];

    always #(PERIOD/2) clk = ~clk;

    blkdma_chan dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .pin_valid(pin_valid), .pin_data(pin_data), .pin_ready(pin_ready),
        .pout_valid(pout_valid), .pout_data(pout_data), .pout_ready(pout_ready)
    );

    function automatic logic [15:0] pat(input int idx, input logic [15:0] s);
        return 16'(idx * 16'h0107) ^ s;
    endfunction

    // memory model: acknowledges every other cycle
    assign mem_ack   = mem_req && stall_q;
    assign mem_rdata = pat(int'(mem_addr[8:1]), seed);
    always @(posedge clk) begin
        stall_q <= ~stall_q;
        if (mem_req && mem_ack && mem_we) wmem[mem_addr[8:1]] <= mem_wdata;
    end

    // peripheral source and sink
    assign pin_valid  = src_on;
    assign pin_data   = 16'(src_seq);
    assign pout_ready = sink_on;
    always @(posedge clk) begin
        if (pin_valid && pin_ready) src_seq <= src_seq + 1;
        if (pout_valid && pout_ready) begin
            sink[sink_n % 1024] <= pout_data;
            sink_n <= sink_n + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] m;
        int polls = 0;
        m = 0;
        while (!m[6] && polls < 3000) begin
            rd(3'd0, m);
            polls++;
        end
        check(m[6], tag, m, m | 32'h40);
    endtask

    task automatic run_to_mem(input logic [31:0] la, input int n, input bit ie);
        logic [31:0] v, base;
        int s, bad;
        src_on = 1'b0;
        wr(3'd0, M_CLRF);
        s = src_seq;
        base = la & 32'hFFFF_FFC0;
        src_on = 1'b1;
        wr(3'd1, la);
        wr(3'd0, M_EN | M_DIR | (ie ? M_IE : 32'd0));
        wr(3'd2, 32'(n));
        wait_done("R5 pending after last block");
        src_on = 1'b0;
        @(negedge clk);
        check(irq == ie, "R5 irq gated by enable", 32'(irq), 32'(ie));
        rd(3'd3, v);
        check(v == base + 32'(64 * n), "R4 current address after blocks", v, base + 32'(64 * n));
        bad = 0;
        for (int k = 0; k < 32 * n; k++)
            if (wmem[(int'(base >> 1) + k) % 256] != 16'(s + k)) bad++;
        check(bad == 0, "R12 memory contents to-memory", 32'(bad), 32'd0);
        wr(3'd2, 32'd0);
        @(negedge clk);
        check(irq == 1'b0, "R6 count write clears irq", 32'(irq), 32'd0);
        wr(3'd0, 32'd0);
    endtask

    task automatic run_from_mem(input logic [31:0] la, input int n);
        logic [31:0] v, base;
        int b, bad, waits;
        wr(3'd0, M_CLRF);
        base = la & 32'hFFFF_FFC0;
        b = sink_n;
        wr(3'd1, la);
        wr(3'd0, M_EN | M_IE);
        wr(3'd2, 32'(n));
        wait_done("R5 pending after last block");
        waits = 0;
        while (sink_n - b < 32 * n && waits < 500) begin
            @(negedge clk);
            waits++;
        end
        rd(3'd3, v);
        check(v == base + 32'(64 * n), "R4 current address after blocks", v, base + 32'(64 * n));
        bad = 0;
        for (int k = 0; k < 32 * n; k++)
            if (sink[(b + k) % 1024] != pat((int'(base >> 1) + k) % 256, seed)) bad++;
        check(bad == 0 && sink_n - b == 32 * n, "R13 peripheral data from memory",
              32'(sink_n - b), 32'(32 * n));
        check(bad == 0, "R13 data mismatches", 32'(bad), 32'd0);
        wr(3'd2, 32'd0);
        wr(3'd0, 32'd0);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s, bad, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check(v == 32'h20, "R1 mode after reset", v, 32'h20);
        rd(3'd2, v); check(v == 0, "R1 count after reset", v, 0);
        rd(3'd3, v); check(v == 0, "R1 current address after reset", v, 0);
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);

        // R2 load address alignment
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); check(v == 32'hFFFF_FFC0, "R2 load address masked", v, 32'hFFFF_FFC0);

        // R8 / R7 CPU FIFO access
        wr(3'd0, M_CLRF);
        wr(3'd0, M_EN);
        wr(3'd4, 32'h1111); wr(3'd4, 32'h2222); wr(3'd4, 32'h3333);
        rd(3'd0, v); check(v == 32'h103, "R7 mode level three", v, 32'h103);
        rd(3'd4, v); check(v == 32'h1111, "R8 FIFO head read", v, 32'h1111);
        rd(3'd0, v); check(v == 32'h102, "R8 level after pop", v, 32'h102);
        wr(3'd0, 32'd0);
        wr(3'd4, 32'h4444);
        rd(3'd4, v);
        wr(3'd0, M_EN);
        rd(3'd0, v); check(v == 32'h102, "R8 access ignored while disabled", v, 32'h102);
        rd(3'd4, v); check(v == 32'h2222, "R8 order kept", v, 32'h2222);

        // R9 clear FIFO
        wr(3'd0, M_EN | M_CLRF);
        rd(3'd0, v); check(v == 32'h120, "R9 clear empties FIFO", v, 32'h120);

        // R10 error flag
        rd(3'd4, v);
        rd(3'd0, v); check(v == 32'h1A0, "R10 underflow sets error", v, 32'h1A0);
        wr(3'd0, M_EN | M_CLRE);
        rd(3'd0, v); check(v == 32'h120, "R10 clear error", v, 32'h120);
        for (int k = 0; k < 33; k++) wr(3'd4, 32'(k));
        rd(3'd0, v); check(v == 32'h180, "R10 overflow sets error, R7 full level", v, 32'h180);
        wr(3'd0, M_CLRE | M_CLRF);
        rd(3'd0, v); check(v == 32'h20, "R10 R9 both cleared", v, 32'h20);

        // sweep: both directions, 1..3 blocks, aligned and unaligned load
        sink_on = 1'b1;
        for (int n = 1; n <= 3; n++) begin
            run_to_mem(32'h40, n, 1'b1);
            run_to_mem(32'h8B, n, 1'b1);
            seed = seed + 16'h0911;
            run_from_mem(32'h00, n);
            run_from_mem(32'hC7, n);
        end

        // R5 interrupt enable off
        run_to_mem(32'h100, 1, 1'b0);
        rd(3'd0, v); check(v[6] == 1'b0, "R6 pending cleared after count write", v, v & ~32'h40);

        // R3 chaining to a new address without rewriting mode
        src_on = 1'b0;
        wr(3'd0, M_CLRF);
        s = src_seq;
        src_on = 1'b1;
        wr(3'd1, 32'h0);
        wr(3'd0, M_EN | M_DIR | M_IE);
        wr(3'd2, 32'd1);
        wait_done("R5 first segment");
        wr(3'd1, 32'h140);
        wr(3'd2, 32'd1);
        @(negedge clk);
        check(irq == 1'b0, "R6 chain write clears irq", 32'(irq), 0);
        wait_done("R3 second segment done");
        src_on = 1'b0;
        bad = 0;
        for (int k = 0; k < 32; k++)
            if (wmem[(32'h140 >> 1) + k] != 16'(s + 32 + k)) bad++;
        check(bad == 0, "R3 chained segment at new address", 32'(bad), 0);
        rd(3'd3, v); check(v == 32'h180, "R3 R4 chained current address", v, 32'h180);
        wr(3'd2, 32'd0);
        wr(3'd0, 32'd0);

        // R11 stop sequence mid-transfer
        wr(3'd0, M_CLRF);
        wr(3'd1, 32'h0);
        wr(3'd0, M_EN);
        wr(3'd2, 32'd5);
        repeat (40) @(negedge clk);
        wr(3'd2, 32'd0);
        wr(3'd0, 32'd0);
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (mem_req) cnt++;
        end
        check(cnt == 0, "R11 no requests after stop", 32'(cnt), 0);
        rd(3'd2, v); check(v == 0, "R11 count zero after stop", v, 0);
        check(irq == 1'b0, "R11 no irq after stop", 32'(irq), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule